// File: doc/BRIEF.md
# Relative Branch Condition Unit

This block decides whether a conditional relative branch is taken and works out where it goes. Each evaluation takes a 4-bit condition selector, the four arithmetic flags (negative, zero, overflow, carry) left by an earlier operation, the address of the instruction after the branch, and a displacement. The displacement is either a short 8-bit form, which is sign-extended, or a long 16-bit form.

The selector covers three kinds of test:
- the unconditional pair, always and never;
- tests of a single flag;
- magnitude comparisons that read the flags left by a subtract or compare. The signed comparisons take the overflow flag into account, so they stay correct when that subtraction overflowed. The unsigned comparisons use the borrow held in carry.

The decision and the target are captured together in an output register whenever the evaluate enable is high. The target is produced for every condition, including never.

Top module: `rel_branch_unit`

## Requirements
- R1: While `rst_n` is low, `br_taken` and `br_target` are 0. The reset is released through a two-stage synchronizer, so the outputs first take a new value at the third rising edge after `rst_n` rises.
- R2: At a rising edge with `eval_en` high, the outputs take the result for the inputs present before that edge. With `eval_en` low, the outputs hold.
- R3: `cond_sel[3:1]` selects one of eight base conditions and `cond_sel[0]`=1 inverts it. The codes, in hexadecimal, are:
  - 0 always, 1 never;
  - 2 unsigned higher, 3 unsigned lower-or-same;
  - 4 carry clear (unsigned higher-or-same), 5 carry set (unsigned lower);
  - 6 not equal, 7 equal;
  - 8 overflow clear, 9 overflow set;
  - A plus, B minus;
  - C signed greater-or-equal, D signed less;
  - E signed greater, F signed less-or-equal.
- R4: Code 0 is always taken and code 1 is never taken, whatever the flags.
- R5: Codes 4 to B each test one flag: carry clear or set, Z=0 or Z=1, V=0 or V=1, N=0 or N=1.
- R6: Unsigned higher is taken when C=0 and Z=0. Lower-or-same is taken when C=1 or Z=1.
- R7: Signed less is N xor V, and greater-or-equal is its inverse. Less-or-equal is Z or (N xor V), and greater is its inverse. These results hold when V=1.
- R8: With `offset_long`=0, only `offset[7:0]` is used. It is sign-extended to 16 bits and added to `next_pc`. The sum wraps modulo 2^16.
- R9: With `offset_long`=1, the full 16-bit `offset` is added to `next_pc`, modulo 2^16.
- R10: `br_target` holds the computed target whether or not the branch is taken, including for code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_en | input | 1 | Capture a new decision and target at this edge |
| cond_sel | input | 4 | Condition selector |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry / borrow flag |
| next_pc | input | 16 | Address of the instruction after the branch |
| offset | input | 16 | Displacement; only bits 7:0 are used in the short form |
| offset_long | input | 1 | 1 selects the 16-bit displacement |
| br_taken | output | 1 | Registered branch decision |
| br_target | output | 16 | Registered branch target |

## Verification
The condition decision and the target addition are completed in the same evaluation cycle, and both land in the same output register. The vector table therefore pairs each condition with a displacement case: short forward, short backward, long, and wrap-around in both directions. The decision and the target are then compared in the same sampled cycle. The never code and untaken conditions are included, to show that the target is still produced when the decision is false.

// File: rtl/rbu_pkg.sv
package rbu_pkg;

  // Base conditions selected by cond_sel[3:1]; cond_sel[0] inverts.
  typedef enum logic [2:0] {
    BC_ALWAYS   = 3'd0,
    BC_UHIGHER  = 3'd1,
    BC_CARRY_CL = 3'd2,
    BC_NOT_ZERO = 3'd3,
    BC_OVF_CL   = 3'd4,
    BC_PLUS     = 3'd5,
    BC_SGE      = 3'd6,
    BC_SGT      = 3'd7
  } base_cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/rbu_rst_sync.sv
module rbu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_ok = sync_q[STAGES-1];

endmodule

// File: rtl/rbu_cond_eval.sv
module rbu_cond_eval
  import rbu_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0] sel,
  input  flags_t           flags,
  output logic             taken
);

  localparam int BASES = 1 << (SEL_W - 1);

  logic [BASES-1:0] base_vec;
  logic             lt_signed;
  logic             le_signed;
  logic             ls_unsigned;

  always_comb begin
    lt_signed   = flags.n ^ flags.v;
    le_signed   = flags.z | lt_signed;
    ls_unsigned = flags.c | flags.z;
  end

  generate
    for (genvar g = 0; g < BASES; g++) begin : g_base
      always_comb begin
        case (base_cond_e'(g))
          BC_ALWAYS:   base_vec[g] = 1'b1;
          BC_UHIGHER:  base_vec[g] = ~ls_unsigned;
          BC_CARRY_CL: base_vec[g] = ~flags.c;
          BC_NOT_ZERO: base_vec[g] = ~flags.z;
          BC_OVF_CL:   base_vec[g] = ~flags.v;
          BC_PLUS:     base_vec[g] = ~flags.n;
          BC_SGE:      base_vec[g] = ~lt_signed;
          BC_SGT:      base_vec[g] = ~le_signed;
          default:     base_vec[g] = 1'b0;
        endcase
      end
    end
  endgenerate

  always_comb begin
    taken = base_vec[sel[SEL_W-1:1]] ^ sel[0];
  end

endmodule

// File: rtl/rbu_target_calc.sv
module rbu_target_calc #(
  parameter int ADDR_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic [ADDR_W-1:0] base_pc,
  input  logic [ADDR_W-1:0] disp,
  input  logic              disp_long,
  output logic [ADDR_W-1:0] target
);

  localparam int EXT_W = ADDR_W - SHORT_W;

  logic [ADDR_W-1:0] disp_ext;

  always_comb begin
    if (disp_long) begin
      disp_ext = disp;
    end else begin
      disp_ext = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
    end
    target = base_pc + disp_ext;
  end

endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
  import rbu_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SHORT_W = 8,
  parameter int SEL_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_en,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_c,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [ADDR_W-1:0] offset,
  input  logic              offset_long,
  output logic              br_taken,
  output logic [ADDR_W-1:0] br_target
);

  logic              rst_ok;
  flags_t            flags;
  logic              taken_c;
  logic [ADDR_W-1:0] target_c;
  logic              taken_d;
  logic [ADDR_W-1:0] target_d;
  logic              taken_q;
  logic [ADDR_W-1:0] target_q;

  rbu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  always_comb begin
    flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};
  end

  rbu_cond_eval #(.SEL_W(SEL_W)) u_cond (
    .sel   (cond_sel),
    .flags (flags),
    .taken (taken_c)
  );

  rbu_target_calc #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_tgt (
    .base_pc   (next_pc),
    .disp      (offset),
    .disp_long (offset_long),
    .target    (target_c)
  );

  // next-state
  always_comb begin
    taken_d  = taken_q;
    target_d = target_q;
    if (eval_en) begin
      taken_d  = taken_c;
      target_d = target_c;
    end
  end

  // state
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      taken_q  <= 1'b0;
      target_q <= '0;
    end else begin
      taken_q  <= taken_d;
      target_q <= target_d;
    end
  end

  assign br_taken  = taken_q;
  assign br_target = target_q;

endmodule

// File: rtl/rel_branch_unit_chk.sv
module rel_branch_unit_chk #(
  parameter int ADDR_W  = 16,
  parameter int SHORT_W = 8,
  parameter int SEL_W   = 4
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              eval_en,
  input logic [SEL_W-1:0]  cond_sel,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_v,
  input logic              flag_c,
  input logic [ADDR_W-1:0] next_pc,
  input logic [ADDR_W-1:0] offset,
  input logic              offset_long,
  input logic              br_taken,
  input logic [ADDR_W-1:0] br_target
);

  // R2: outputs hold while not evaluating
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    !eval_en |=> ($stable(br_taken) && $stable(br_target)));

  // R4: code 0 always taken
  a_r4_always: assert property (@(posedge clk) disable iff (!rst_ok)
    (eval_en && cond_sel == 4'h0) |=> br_taken);

  // R4: code 1 never taken
  a_r4_never: assert property (@(posedge clk) disable iff (!rst_ok)
    (eval_en && cond_sel == 4'h1) |=> !br_taken);

  // R5: carry set follows C
  a_r5_carry_set: assert property (@(posedge clk) disable iff (!rst_ok)
    (eval_en && cond_sel == 4'h5) |=> (br_taken == $past(flag_c)));

  // R7: signed less is N xor V
  a_r7_signed_less: assert property (@(posedge clk) disable iff (!rst_ok)
    (eval_en && cond_sel == 4'hD) |=> (br_taken == ($past(flag_n) ^ $past(flag_v))));

  // R6: lower-or-same taken whenever carry or zero is set
  a_r6_lower_same: assert property (@(posedge clk) disable iff (!rst_ok)
    (eval_en && cond_sel == 4'h3 && (flag_c || flag_z)) |=> br_taken);

  // R9: long form adds the full displacement
  a_r9_long_target: assert property (@(posedge clk) disable iff (!rst_ok)
    (eval_en && offset_long) |=>
      (br_target == ADDR_W'($past(next_pc) + $past(offset))));

endmodule

bind rel_branch_unit rel_branch_unit_chk #(
  .ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .SEL_W(SEL_W)
) u_rel_branch_unit_chk (
  .clk         (clk),
  .rst_ok      (rst_ok),
  .eval_en     (eval_en),
  .cond_sel    (cond_sel),
  .flag_n      (flag_n),
  .flag_z      (flag_z),
  .flag_v      (flag_v),
  .flag_c      (flag_c),
  .next_pc     (next_pc),
  .offset      (offset),
  .offset_long (offset_long),
  .br_taken    (br_taken),
  .br_target   (br_target)
);

// File: tb/rel_branch_unit_bench.sv
module rel_branch_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;
  localparam int WATCHDOG = 5000;

  // {sel[4], nzvc[4], long, pc[16], off[16], exp_taken, exp_target[16]}
  localparam logic [57:0] VEC [NVEC] = '{
    {4'h0, 4'b0000, 1'b0, 16'h1000, 16'h0010, 1'b1, 16'h1010}, // R4 always
    {4'h1, 4'b1111, 1'b0, 16'h1000, 16'h00F0, 1'b0, 16'h0FF0}, // R4 never, R10
    {4'h2, 4'b0000, 1'b0, 16'h2000, 16'h007F, 1'b1, 16'h207F}, // R6 higher
    {4'h3, 4'b0100, 1'b0, 16'h2000, 16'h0080, 1'b1, 16'h1F80}, // R6 ls, R8
    {4'h4, 4'b0001, 1'b1, 16'h3000, 16'h1234, 1'b0, 16'h4234}, // R5, R9
    {4'h5, 4'b0001, 1'b1, 16'hF000, 16'h2000, 1'b1, 16'h1000}, // R5, R9 wrap
    {4'h6, 4'b0100, 1'b0, 16'h0100, 16'h0002, 1'b0, 16'h0102}, // R5 ne
    {4'h7, 4'b0100, 1'b0, 16'h0100, 16'h00FE, 1'b1, 16'h00FE}, // R5 eq
    {4'h8, 4'b0010, 1'b0, 16'h0050, 16'h0001, 1'b0, 16'h0051}, // R5 vc
    {4'h9, 4'b0010, 1'b0, 16'h0050, 16'h0001, 1'b1, 16'h0051}, // R5 vs
    {4'hA, 4'b1000, 1'b0, 16'h0000, 16'h0005, 1'b0, 16'h0005}, // R5 pl
    {4'hB, 4'b1000, 1'b0, 16'h0000, 16'h00FF, 1'b1, 16'hFFFF}, // R5 mi, R8 wrap
    {4'hC, 4'b1010, 1'b0, 16'h4000, 16'h0010, 1'b1, 16'h4010}, // R7 ge with V
    {4'hD, 4'b0010, 1'b0, 16'h4000, 16'h0010, 1'b1, 16'h4010}, // R7 lt with V
    {4'hE, 4'b0100, 1'b0, 16'h4000, 16'h0010, 1'b0, 16'h4010}, // R7 gt, Z
    {4'hF, 4'b1000, 1'b1, 16'h4000, 16'hFFFE, 1'b1, 16'h3FFE}, // R7 le, R9
    {4'hE, 4'b1010, 1'b0, 16'h4000, 16'h0020, 1'b1, 16'h4020}, // R7 gt with V
    {4'h2, 4'b0001, 1'b0, 16'h1234, 16'h0000, 1'b0, 16'h1234}, // R6 higher, C
    {4'h0, 4'b0000, 1'b0, 16'h8000, 16'hAB05, 1'b1, 16'h8005}  // R8 upper ignored
  };

  logic        clk;
  logic        rst_n;
  logic        eval_en;
  logic [3:0]  cond_sel;
  logic        flag_n, flag_z, flag_v, flag_c;
  logic [15:0] next_pc;
  logic [15:0] offset;
  logic        offset_long;
  logic        br_taken;
  logic [15:0] br_target;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  rel_branch_unit u_rel_branch_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .eval_en     (eval_en),
    .cond_sel    (cond_sel),
    .flag_n      (flag_n),
    .flag_z      (flag_z),
    .flag_v      (flag_v),
    .flag_c      (flag_c),
    .next_pc     (next_pc),
    .offset      (offset),
    .offset_long (offset_long),
    .br_taken    (br_taken),
    .br_target   (br_target)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic string tag_of(input logic [3:0] s);
    if (s < 4'h2) return "R4";
    if (s < 4'h4) return "R6";
    if (s < 4'hC) return "R5";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [57:0] v, input logic en);
    @(negedge clk);
    eval_en     = en;
    cond_sel    = v[57:54];
    {flag_n, flag_z, flag_v, flag_c} = v[53:50];
    offset_long = v[49];
    next_pc     = v[48:33];
    offset      = v[32:17];
  endtask

  initial begin
    rst_n = 1'b0; eval_en = 1'b0; cond_sel = '0;
    {flag_n, flag_z, flag_v, flag_c} = '0;
    next_pc = '0; offset = '0; offset_long = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {15'd0, br_taken}, 16'd0);
    check("R1", br_target, 16'd0);

    // R1: synchronized release, evaluating code 0 throughout
    apply(VEC[0], 1'b1);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", {15'd0, br_taken}, 16'd0);
    @(posedge clk); #1;
    check("R1", br_target, 16'd0);
    @(posedge clk); #1;
    check("R1", {15'd0, br_taken}, 16'd1);
    check("R1", br_target, 16'h1010);

    // Vector table: R3 encoding, decision and target land in one cycle
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i], 1'b1);
      @(posedge clk); #1;
      check(tag_of(VEC[i][57:54]), {15'd0, br_taken}, {15'd0, VEC[i][16]});
      check(VEC[i][49] ? "R9" : "R8", br_target, VEC[i][15:0]); // R10 for untaken rows
    end

    // R2: hold with enable low while inputs change
    apply(VEC[1], 1'b0);
    @(posedge clk); #1;
    check("R2", {15'd0, br_taken}, 16'd1);
    check("R2", br_target, 16'h8005);
    apply(VEC[5], 1'b0);
    @(posedge clk); #1;
    check("R2", br_target, 16'h8005);
    apply(VEC[5], 1'b1);
    @(posedge clk); #1;
    check("R2", br_target, 16'h1000);

    // R1: asynchronous assertion mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", {15'd0, br_taken}, 16'd0);
    check("R1", br_target, 16'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule